// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block sits on the receive side of an Ethernet MAC and decides whether a frame addressed to a multicast group should be kept. The 48-bit destination address enters one byte per strobe, in wire order. While the bytes arrive, the block runs a CRC-32 over them. The eight most significant bits of the bit-reversed remainder form an index into a 256-entry bitmap, and the bitmap bit at that index gives the accept/reject result. Unicast addresses never look up the bitmap; they are always rejected.

The bitmap is held in eight 32-bit registers. Software writes and reads these registers through a simple port. Register order and bit order are MSB-first: bitmap entry 0 is bit 31 of register 0, and entry 255 is bit 0 of register 7. Software sets or clears a single entry by reading the register, changing the one bit and writing the register back.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, all eight table registers read as zero, and `done` and `accept` are low.
- R2: When `reg_wr_en` is high at a clock edge, the register chosen by `reg_sel` takes the whole of `reg_wdata`, and the other seven registers keep their values. `reg_rdata` always shows, without delay, the register chosen by `reg_rd_sel`.
- R3: A byte taken with `addr_valid` and `addr_start` both high is byte 0 of a new address, and any partial address in progress is discarded. The next five bytes taken with `addr_valid` high complete the address. Idle cycles between bytes are allowed.
- R4: The hash is a CRC-32 with generator polynomial 0x04C11DB7. The remainder starts at all ones, each byte enters least significant bit first, and no final inversion is applied. The index is the 8 most significant bits of the remainder in normal (non-reflected) bit order, which is the same as the reflected register bit-reversed.
- R5: Index bits [7:5] choose the table register. Index bits [4:0], read as a number n, choose bit 31-n of that register.
- R6: `done` is high for exactly one cycle. It rises in the cycle after the edge that takes the sixth byte. `accept` is valid while `done` is high and is low at all other times.
- R7: The group bit is bit 0 of byte 0. When it is 0, `accept` stays low, whatever the table holds.
- R8: If a table write happens at the same edge that takes the sixth byte, that lookup uses the table as it was before the write. The next lookup uses the new value.
- R9: Bytes taken after a completed address, without a new `addr_start`, are ignored and produce no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_start | input | 1 | Marks byte 0 of an address (used together with addr_valid) |
| addr_valid | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte, in wire order |
| reg_wr_en | input | 1 | Table register write strobe |
| reg_sel | input | 3 | Register selected for a write |
| reg_wdata | input | 32 | Data written to the register |
| reg_rd_sel | input | 3 | Register selected for a read |
| reg_rdata | output | 32 | Contents of the selected register |
| done | output | 1 | One-cycle pulse: lookup result is valid |
| accept | output | 1 | Frame accepted (valid while done is high) |

## Verification
Several multicast addresses are hashed twice. The first time, only the predicted table bit is set, so the frame must be accepted. The second time, every bit except the predicted one is set, so the frame must be rejected. Together these two runs separate a correct CRC, index extraction and MSB-first bit placement from any neighbouring bit or register. A unicast address with a table of all ones tests the group-bit bypass. Further tests cover:
- addresses delivered with idle gaps between bytes;
- an address restarted part-way through;
- stray bytes sent after a completed address;
- a table write that lands on the same edge as the sixth byte, which tests the ordering between writes and lookups.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter int          NREGS      = 8,
  parameter int          REG_W      = 32,
  parameter logic [31:0] POLY_REFL  = 32'hEDB88320
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     addr_start,
  input  logic                     addr_valid,
  input  logic [7:0]               addr_byte,
  input  logic                     reg_wr_en,
  input  logic [$clog2(NREGS)-1:0] reg_sel,
  input  logic [REG_W-1:0]         reg_wdata,
  input  logic [$clog2(NREGS)-1:0] reg_rd_sel,
  output logic [REG_W-1:0]         reg_rdata,
  output logic                     done,
  output logic                     accept
);
  localparam int SEL_W = $clog2(NREGS);
  localparam int BIT_W = $clog2(REG_W);
  localparam int IDX_W = SEL_W + BIT_W;
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [REG_W-1:0] tbl [NREGS];
  logic [31:0]      crc_q, crc_in, crc_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_in;
  logic             grp_q, grp_eff;
  logic [IDX_W-1:0] idx;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
    return r;
  endfunction

  assign crc_in  = addr_start ? 32'hFFFF_FFFF : crc_q;
  assign cnt_in  = addr_start ? '0 : cnt_q;
  assign crc_nxt = crc_byte(crc_in, addr_byte);
  assign grp_eff = (cnt_in == '0) ? addr_byte[0] : grp_q;

  always_comb
    for (int i = 0; i < IDX_W; i++)
      idx[IDX_W-1-i] = crc_nxt[i];

  assign reg_rdata = tbl[reg_rd_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= '1;
      cnt_q  <= IDLE;
      grp_q  <= 1'b0;
      done   <= 1'b0;
      accept <= 1'b0;
    end else begin
      done   <= 1'b0;
      accept <= 1'b0;
      if (addr_valid && cnt_in != IDLE) begin
        crc_q <= crc_nxt;
        grp_q <= grp_eff;
        if (cnt_in == LAST) begin
          cnt_q  <= IDLE;
          done   <= 1'b1;
          accept <= grp_eff & tbl[idx[IDX_W-1 -: SEL_W]][~idx[BIT_W-1:0]];
        end else begin
          cnt_q <= cnt_in + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl[g] <= '0;
      else if (reg_wr_en && reg_sel == SEL_W'(g))
        tbl[g] <= reg_wdata;
    end
  end
endmodule

module mcast_hash_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_valid,
  input logic        reg_wr_en,
  input logic [2:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic [2:0]  reg_rd_sel,
  input logic [31:0] reg_rdata,
  input logic        done,
  input logic        accept,
  input logic        grp_q
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !accept);
  assert_done_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(addr_valid));
  assert_unicast_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !grp_q) |-> !accept);
  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr_en) && $past(rst_n) && reg_rd_sel == $past(reg_sel)) |-> reg_rdata == $past(reg_wdata));
endmodule

bind mcast_hash_filter mcast_hash_filter_chk chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .reg_wr_en(reg_wr_en),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rd_sel(reg_rd_sel),
  .reg_rdata(reg_rdata), .done(done), .accept(accept), .grp_q(grp_q)
);

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        addr_start = 0, addr_valid = 0;
  logic [7:0]  addr_byte = 0;
  logic        reg_wr_en = 0;
  logic [2:0]  reg_sel = 0, reg_rd_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        done, accept;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  mcast_hash_filter dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] model_idx(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ a[8*k+i];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c[31:24];
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic fill(input logic [31:0] d);
    for (int r = 0; r < 8; r++) wr(3'(r), d);
  endtask

  task automatic send(input logic [47:0] a, input int gap, input string req, input logic exp_acc);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      addr_valid = 1; addr_start = (k == 0); addr_byte = a[8*k +: 8];
      if (k < 5) for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        addr_valid = 0; addr_start = 0;
        chk({req, " no early done"}, 32'(done), 0);
      end
    end
    @(negedge clk);
    addr_valid = 0; addr_start = 0;
    chk({req, " done"}, 32'(done), 1);
    chk({req, " accept"}, 32'(accept), 32'(exp_acc));
    @(negedge clk);
    chk({req, " done single R6"}, 32'(done), 0);
    chk({req, " accept low R6"}, 32'(accept), 0);
  endtask

  task automatic t_reset_R1;
    for (int r = 0; r < 8; r++) begin
      reg_rd_sel = 3'(r); #1;
      chk("R1 table zero", reg_rdata, 0);
    end
    chk("R1 done", 32'(done), 0);
    chk("R1 accept", 32'(accept), 0);
  endtask

  task automatic t_regs_R2;
    wr(3, 32'hA5A5_0F0F);
    for (int r = 0; r < 8; r++) begin
      reg_rd_sel = 3'(r); #1;
      chk("R2 readback", reg_rdata, (r == 3) ? 32'hA5A5_0F0F : 0);
    end
    wr(3, 32'h0000_0001);
    reg_rd_sel = 3; #1;
    chk("R2 overwrite", reg_rdata, 32'h1);
    fill(0);
  endtask

  task automatic t_hash_R4_R5(input logic [47:0] a);
    logic [7:0] ix;
    ix = model_idx(a);
    fill(0);
    wr(ix[7:5], 32'h1 << (31 - ix[4:0]));
    send(a, 0, "R4 R5 only-bit", 1);
    fill(32'hFFFF_FFFF);
    wr(ix[7:5], ~(32'h1 << (31 - ix[4:0])));
    send(a, 0, "R4 R5 all-but-bit", 0);
  endtask

  task automatic t_unicast_R7;
    fill(32'hFFFF_FFFF);
    send(48'h5544_3322_1100, 0, "R7 unicast", 0);
    send(48'h5544_3322_1101, 0, "R7 multicast all-ones", 1);
  endtask

  task automatic t_gaps_R3;
    logic [47:0] a = 48'h0B0A_0908_0701;
    logic [7:0] ix = model_idx(a);
    fill(0);
    wr(ix[7:5], 32'h1 << (31 - ix[4:0]));
    send(a, 2, "R3 gaps", 1);
  endtask

  task automatic t_restart_R3;
    logic [47:0] a = 48'h6655_4433_2201;
    logic [7:0] ix = model_idx(a);
    fill(0);
    wr(ix[7:5], 32'h1 << (31 - ix[4:0]));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      addr_valid = 1; addr_start = (k == 0); addr_byte = 8'hF0 + 8'(k);
    end
    send(a, 0, "R3 restart", 1);
  endtask

  task automatic t_stray_R9;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      addr_valid = 1; addr_start = 0; addr_byte = 8'h01;
      if (k > 0) chk("R9 stray bytes no done", 32'(done), 0);
    end
    @(negedge clk);
    addr_valid = 0;
    chk("R9 stray bytes no done", 32'(done), 0);
  endtask

  task automatic t_same_cycle_R8;
    logic [47:0] a = 48'hC0FF_EE12_3401;
    logic [7:0] ix = model_idx(a);
    fill(0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      addr_valid = 1; addr_start = (k == 0); addr_byte = a[8*k +: 8];
      if (k == 5) begin
        reg_wr_en = 1; reg_sel = ix[7:5]; reg_wdata = 32'h1 << (31 - ix[4:0]);
      end
    end
    @(negedge clk);
    addr_valid = 0; addr_start = 0; reg_wr_en = 0;
    chk("R8 same-cycle done", 32'(done), 1);
    chk("R8 same-cycle old table", 32'(accept), 0);
    send(a, 0, "R8 next lookup new table", 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R1();
    rst_n = 1;
    @(negedge clk);
    t_reset_R1();
    t_regs_R2();
    t_hash_R4_R5(48'h0000_5E00_0001);
    t_hash_R4_R5(48'h0000_0000_0033);
    t_hash_R4_R5(48'hFFFF_FFFF_FFFF);
    t_hash_R4_R5(48'h1234_5678_9A01);
    t_unicast_R7();
    t_gaps_R3();
    t_restart_R3();
    t_stray_R9();
    t_same_cycle_R8();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule